// File: doc/BRIEF.md
# Accumulated-Boundary Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel RGB panel, one pixel per clock. Software programs the raster as running totals instead of separate porch lengths. Each boundary is the previous one plus the next interval: the sync width minus one, then the back porch, then the visible size, then the front porch. Two free-running counters walk each line and frame. Every output strobe is a plain comparison of a counter against one of these boundaries.

The timing boundaries and the background colour are written into a shadow set. They only reach the active set on a reload request. The request either copies at once or waits for the end of the current frame, so a mode change never tears a frame. The control word holds the enable and the output polarities and takes effect directly. A sticky flag marks entry into a chosen line. A packed status word reports the live counter values. The colour output gives the pixel value to use wherever no layer covers the raster.

Top module: `raster_timing_gen`

## Requirements
- R1: Word address 0 holds sync width minus one, 1 the accumulated back porch, 2 the accumulated active end, and 3 the total. Each of these packs the horizontal value in bits 27:16 and the vertical value in bits 10:0.
- R2: The horizontal counter runs from 0 to the active horizontal total inclusive, then returns to 0 and advances the vertical counter. The vertical counter wraps to 0 after its total. posStatus carries the horizontal count in bits 27:16 and the vertical count in bits 10:0, with all other bits zero.
- R3: Horizontal sync is active while the horizontal count is at most the sync value. Vertical sync is active while the vertical count is at most its sync value.
- R4: Data-enable is active when the horizontal count lies above the accumulated back porch and at or below the accumulated active end, and the vertical count satisfies the same condition against its own boundaries.
- R5: In the control word at address 4, bit 31 makes hsync active-high, bit 30 vsync and bit 29 data-enable. A cleared bit makes the signal active-low. Bit 28 is driven out unchanged on pclkInvert.
- R6: Control bit 0 enables the raster. While it is clear, both counters are held at 0 and hsync, vsync and de sit at their inactive levels.
- R7: Writes to addresses 0 to 3 and to the colour word at address 7 have no effect on the outputs until a reload. Writing bit 0 of address 5 copies the shadow set into the active set at the clock edge after the write.
- R8: Writing bit 1 of address 5 defers the copy to the edge on which both counters wrap to 0, or to the next edge if the raster is disabled. Both request bits clear after one copy, so later shadow writes need a new request.
- R9: lineIrq sets on the edge after the counters sit at horizontal 0 and vertical equal to the line value in address 6, bits 10:0, while enabled. It stays set until a write with bit 0 set to address 8. A set and a clear on the same edge leave it set.
- R10: bgColor shows the active 32-bit background colour, loaded through the shadow path of R7 and R8.
- R11: If a reload leaves a counter above its new total, that counter returns to 0 on the next step instead of running on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register word address |
| wrData | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| de | output | 1 | Data-enable, programmable polarity |
| pclkInvert | output | 1 | Request to sample pixel data on the opposite clock edge |
| posStatus | output | 32 | Packed current horizontal and vertical position |
| lineIrq | output | 1 | Sticky line-reached flag |
| bgColor | output | 32 | Active ARGB background colour |

## Verification
A behavioural reference model follows every clock through three distinct rasters. The first is a 14-by-7 frame with asymmetric porches, which separates off-by-one errors on each boundary edge. The second puts all polarities low with the clock inversion set, which shows whether each strobe is gated and inverted independently. The third is a reload to a smaller total while the horizontal counter sits above it, which separates a greater-or-equal wrap from an equality wrap. Reloads are tried both deferred and immediate, enabled and disabled, and with a shadow write after a completed copy. These runs tell a working frame-end copy from one that fires early or repeats.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  parameter int H_BITS = 12;
  parameter int V_BITS = 11;
  parameter int ADDR_W = 4;
  parameter int DATA_W = 32;
  localparam int H_LSB = 16;
  localparam int NUM_TREG = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_SYNC   = 4'd0,
    REG_BPORCH = 4'd1,
    REG_ACTIVE = 4'd2,
    REG_TOTAL  = 4'd3,
    REG_CTRL   = 4'd4,
    REG_RELOAD = 4'd5,
    REG_LINE   = 4'd6,
    REG_BGCOL  = 4'd7,
    REG_IRQCLR = 4'd8
  } regSel_e;

  typedef struct packed {
    logic [H_BITS-1:0] syncH;
    logic [H_BITS-1:0] bpH;
    logic [H_BITS-1:0] actH;
    logic [H_BITS-1:0] totH;
    logic [V_BITS-1:0] syncV;
    logic [V_BITS-1:0] bpV;
    logic [V_BITS-1:0] actV;
    logic [V_BITS-1:0] totV;
  } timing_t;

  typedef struct packed {
    logic enable;
    logic hsHigh;
    logic vsHigh;
    logic deHigh;
    logic clkInv;
  } ctlCfg_t;

  typedef struct packed {
    logic frameEnd;
    logic lineHit;
  } dpEvt_t;
endpackage

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
  import rtg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  dpEvt_t              evt,
  output timing_t             actT,
  output ctlCfg_t             cfg,
  output logic [V_BITS-1:0]   linePos,
  output logic [DATA_W-1:0]   bgCol,
  output logic                irqFlag
);
  logic [NUM_TREG-1:0][H_BITS-1:0] actHv;
  logic [NUM_TREG-1:0][V_BITS-1:0] actVv;
  logic [DATA_W-1:0] shBg;
  logic reqImm, reqVb, copyNow;
  logic wrReload, wrClear;

  assign wrReload = wrEn && (wrAddr == REG_RELOAD);
  assign wrClear  = wrEn && (wrAddr == REG_IRQCLR) && wrData[0];
  assign copyNow  = reqImm || (reqVb && (!cfg.enable || evt.frameEnd));

  for (genvar i = 0; i < NUM_TREG; i++) begin : gTreg
    logic [H_BITS-1:0] hSh, hAct;
    logic [V_BITS-1:0] vSh, vAct;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hSh <= '0; vSh <= '0; hAct <= '0; vAct <= '0;
      end else begin
        if (copyNow) begin
          hAct <= hSh;
          vAct <= vSh;
        end
        if (wrEn && (wrAddr == ADDR_W'(i))) begin
          hSh <= wrData[H_LSB +: H_BITS];
          vSh <= wrData[V_BITS-1:0];
        end
      end
    end
    assign actHv[i] = hAct;
    assign actVv[i] = vAct;
  end

  always_comb begin
    actT.syncH = actHv[0];
    actT.bpH   = actHv[1];
    actT.actH  = actHv[2];
    actT.totH  = actHv[3];
    actT.syncV = actVv[0];
    actT.bpV   = actVv[1];
    actT.actV  = actVv[2];
    actT.totV  = actVv[3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shBg <= '0; bgCol <= '0;
      reqImm <= 1'b0; reqVb <= 1'b0;
      cfg <= '0; linePos <= '0; irqFlag <= 1'b0;
    end else begin
      if (copyNow) bgCol <= shBg;
      if (wrEn && (wrAddr == REG_BGCOL)) shBg <= wrData;
      reqImm <= (copyNow ? 1'b0 : reqImm) | (wrReload & wrData[0]);
      reqVb  <= (copyNow ? 1'b0 : reqVb)  | (wrReload & wrData[1]);
      if (wrEn && (wrAddr == REG_CTRL)) begin
        cfg.enable <= wrData[0];
        cfg.clkInv <= wrData[28];
        cfg.deHigh <= wrData[29];
        cfg.vsHigh <= wrData[30];
        cfg.hsHigh <= wrData[31];
      end
      if (wrEn && (wrAddr == REG_LINE)) linePos <= wrData[V_BITS-1:0];
      if (evt.lineHit) irqFlag <= 1'b1;
      else if (wrClear) irqFlag <= 1'b0;
    end
  end

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.lineHit |=> irqFlag);
  // R8
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqVb && evt.frameEnd && !wrReload) |=> !reqVb);
  // R7
  imm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqImm && !wrReload) |=> !reqImm);
endmodule

// File: rtl/rtg_dpath.sv
module rtg_dpath
  import rtg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  timing_t            tim,
  input  ctlCfg_t            cfg,
  input  logic [V_BITS-1:0]  linePos,
  output logic [H_BITS-1:0]  hCnt,
  output logic [V_BITS-1:0]  vCnt,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output dpEvt_t             evt
);
  logic hEnd, vEnd, hsAct, vsAct, deAct;

  assign hEnd = (hCnt >= tim.totH);
  assign vEnd = (vCnt >= tim.totV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCnt <= '0; vCnt <= '0;
    end else if (!cfg.enable) begin
      hCnt <= '0; vCnt <= '0;
    end else if (hEnd) begin
      hCnt <= '0;
      vCnt <= vEnd ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  always_comb begin
    hsAct = cfg.enable && (hCnt <= tim.syncH);
    vsAct = cfg.enable && (vCnt <= tim.syncV);
    deAct = cfg.enable && (hCnt > tim.bpH) && (hCnt <= tim.actH)
                       && (vCnt > tim.bpV) && (vCnt <= tim.actV);
    hsync = cfg.hsHigh ? hsAct : ~hsAct;
    vsync = cfg.vsHigh ? vsAct : ~vsAct;
    de    = cfg.deHigh ? deAct : ~deAct;
    evt.frameEnd = cfg.enable && hEnd && vEnd;
    evt.lineHit  = cfg.enable && (hCnt == '0) && (vCnt == linePos);
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.enable |=> (hCnt == '0 && vCnt == '0));
  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.enable && hCnt < tim.totH) |=> (hCnt == $past(hCnt) + 1'b1));
  // R11
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.enable && hCnt >= tim.totH) |=> (hCnt == '0));
  // R2
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.enable && hCnt < tim.totH) |=> $stable(vCnt));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [31:0]       wrData,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              pclkInvert,
  output logic [31:0]       posStatus,
  output logic              lineIrq,
  output logic [31:0]       bgColor
);
  timing_t           actT;
  ctlCfg_t           cfg;
  dpEvt_t            evt;
  logic [V_BITS-1:0] linePos;
  logic [H_BITS-1:0] hCnt;
  logic [V_BITS-1:0] vCnt;

  rtg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evt(evt), .actT(actT), .cfg(cfg), .linePos(linePos),
    .bgCol(bgColor), .irqFlag(lineIrq)
  );

  rtg_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .tim(actT), .cfg(cfg), .linePos(linePos),
    .hCnt(hCnt), .vCnt(vCnt), .hsync(hsync), .vsync(vsync), .de(de),
    .evt(evt)
  );

  assign pclkInvert = cfg.clkInv;

  always_comb begin
    posStatus = '0;
    posStatus[H_LSB +: H_BITS] = hCnt;
    posStatus[V_BITS-1:0]      = vCnt;
  end
endmodule

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic hsync, vsync, de, pclkInvert, lineIrq;
  logic [31:0] posStatus, bgColor;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hsync(hsync), .vsync(vsync), .de(de), .pclkInvert(pclkInvert),
    .posStatus(posStatus), .lineIrq(lineIrq), .bgColor(bgColor)
  );

  // reference model state
  int mh = 0, mv = 0, mLine = 0;
  int sH[4] = '{0,0,0,0}, sV[4] = '{0,0,0,0};
  int aH[4] = '{0,0,0,0}, aV[4] = '{0,0,0,0};
  bit mEn = 0, mHs = 0, mVs = 0, mDe = 0, mCk = 0, mIrq = 0, rImm = 0, rVb = 0;
  logic [31:0] sBg = '0, aBg = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh = 0; mv = 0; mLine = 0;
      for (int i = 0; i < 4; i++) begin sH[i] = 0; sV[i] = 0; aH[i] = 0; aV[i] = 0; end
      mEn = 0; mHs = 0; mVs = 0; mDe = 0; mCk = 0; mIrq = 0; rImm = 0; rVb = 0;
      sBg = '0; aBg = '0;
    end else begin
      bit fe, hit, cp;
      fe  = mEn && mh >= aH[3] && mv >= aV[3];
      hit = mEn && mh == 0 && mv == mLine;
      cp  = rImm || (rVb && (!mEn || fe));
      if (!mEn) begin mh = 0; mv = 0; end
      else if (mh >= aH[3]) begin mh = 0; if (mv >= aV[3]) mv = 0; else mv = mv + 1; end
      else mh = mh + 1;
      if (hit) mIrq = 1;
      else if (wrEn && wrAddr == 4'd8 && wrData[0]) mIrq = 0;
      if (cp) begin
        for (int i = 0; i < 4; i++) begin aH[i] = sH[i]; aV[i] = sV[i]; end
        aBg = sBg; rImm = 0; rVb = 0;
      end
      if (wrEn) begin
        case (wrAddr)
          4'd0, 4'd1, 4'd2, 4'd3: begin
            sH[wrAddr] = int'(wrData[27:16]);
            sV[wrAddr] = int'(wrData[10:0]);
          end
          4'd4: begin
            mEn = wrData[0]; mCk = wrData[28]; mDe = wrData[29];
            mVs = wrData[30]; mHs = wrData[31];
          end
          4'd5: begin rImm = rImm | wrData[0]; rVb = rVb | wrData[1]; end
          4'd6: mLine = int'(wrData[10:0]);
          4'd7: sBg = wrData;
          default: ;
        endcase
      end
    end
  end

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    bit hA, vA, dA;
    hA = mEn && mh <= aH[0];
    vA = mEn && mv <= aV[0];
    dA = mEn && mh > aH[1] && mh <= aH[2] && mv > aV[1] && mv <= aV[2];
    checkEq("R3 hsync", {31'b0, hsync}, {31'b0, mHs ? hA : !hA});
    checkEq("R3 vsync", {31'b0, vsync}, {31'b0, mVs ? vA : !vA});
    checkEq("R4 de", {31'b0, de}, {31'b0, mDe ? dA : !dA});
    checkEq("R2 posStatus", posStatus, (32'(mh) << 16) | 32'(mv));
    checkEq("R9 lineIrq", {31'b0, lineIrq}, {31'b0, mIrq});
    checkEq("R10 bgColor", bgColor, aBg);
    checkEq("R5 pclkInvert", {31'b0, pclkInvert}, {31'b0, mCk});
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] pk(input int h, input int v);
    return (32'(h) << 16) | 32'(v);
  endfunction

  task automatic waitPos(input logic [31:0] p);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (posStatus == p) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int maxH, maxV;
    repeat (4) @(negedge clk);
    // R6 reset state: active-low polarity, so inactive level is 1
    checkEq("R6 reset hsync", {31'b0, hsync}, 32'd1);
    checkEq("R6 reset de", {31'b0, de}, 32'd1);
    checkEq("R2 reset pos", posStatus, 32'd0);
    rst_n = 1'b1;

    // R1 program 14x7 raster: sync 2/1, bp 2/1, active 8/4, fp 2/1
    wr(4'd0, pk(1, 0));
    wr(4'd1, pk(3, 1));
    wr(4'd2, pk(11, 5));
    wr(4'd3, pk(13, 6));
    wr(4'd7, 32'h11223344);
    wr(4'd6, 32'd6);
    wr(4'd5, 32'd1);
    wr(4'd4, 32'hE000_0001);
    maxH = 0; maxV = 0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (int'(posStatus[27:16]) > maxH) maxH = int'(posStatus[27:16]);
      if (int'(posStatus[10:0]) > maxV) maxV = int'(posStatus[10:0]);
    end
    checkEq("R1 max horizontal", 32'(maxH), 32'd13);
    checkEq("R1 max vertical", 32'(maxV), 32'd6);
    checkEq("R9 flag set", {31'b0, lineIrq}, 32'd1);
    wr(4'd8, 32'd1);
    checkEq("R9 flag cleared", {31'b0, lineIrq}, 32'd0);

    // R7 shadow write without reload
    wr(4'd7, 32'hAABBCCDD);
    repeat (20) @(negedge clk);
    checkEq("R7 shadow held", bgColor, 32'h11223344);

    // R8 deferred reload
    wr(4'd5, 32'd2);
    checkEq("R8 not yet copied", bgColor, 32'h11223344);
    waitPos(32'd0);
    checkEq("R8 copied at wrap", bgColor, 32'hAABBCCDD);
    wr(4'd7, 32'h55667788);
    repeat (200) @(negedge clk);
    checkEq("R8 request self-cleared", bgColor, 32'hAABBCCDD);

    // R5 all active-low with clock inversion
    wr(4'd4, 32'h1000_0001);
    repeat (150) @(negedge clk);
    checkEq("R5 pclkInvert", {31'b0, pclkInvert}, 32'd1);

    // R11 shrink totals while horizontal counter is beyond new total
    wr(4'd0, pk(0, 0));
    wr(4'd1, pk(1, 1));
    wr(4'd2, pk(3, 2));
    wr(4'd3, pk(5, 3));
    waitPos(pk(10, 2));
    wr(4'd5, 32'd1);
    repeat (3) @(negedge clk);
    checkEq("R11 wrapped below total", {31'b0, posStatus[27:16] <= 12'd5}, 32'd1);
    repeat (100) @(negedge clk);

    // R6 disable, then R8 deferred reload while disabled
    wr(4'd7, 32'h0F0F0F0F);
    wr(4'd4, 32'h0000_0000);
    repeat (3) @(negedge clk);
    checkEq("R6 idle position", posStatus, 32'd0);
    checkEq("R6 idle vsync", {31'b0, vsync}, 32'd1);
    wr(4'd5, 32'd2);
    @(negedge clk);
    checkEq("R8 copy while disabled", bgColor, 32'h0F0F0F0F);

    wr(4'd4, 32'hE000_0001);
    repeat (100) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule